// File: doc/BRIEF.md
# Stack Transfer Sequencer

This block performs stack transfers between a core's general register file and its word-addressed memory port. The core hands it a one-cycle start pulse together with the decoded extended-opcode field, the number of the register that serves as stack pointer, and, for the single forms, the number of the data register. The stack grows upward. A push advances the pointer register by one word and then stores, and a pop loads and then steps the pointer back by one word.

The multiple forms move the fixed window R0..R15 as a sequence of single-word memory transactions. The pointer register in the file is rewritten after every word. Push-multiple stores R0 first and R15 last. Pop-multiple restores R15 first and R0 last, so a matching pair returns every register to its value. While a transfer runs, `busy_o` stalls the core, and a one-cycle `done_o` marks the end. Every memory access waits for the memory's ready handshake.

Top module: `stack_xfer_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mem_req_o` and `rf_we_o` are all low.
- R2: Single push (extended opcode 21) writes R[sp]+1 into the pointer register sp, then stores R[reg_sel] to memory at that new address. With ready held high, `done_o` is seen 3 cycles after the start edge.
- R3: Single pop (extended opcode 22) loads memory at R[sp] into R[reg_sel], then writes R[sp]-1 into the pointer register. With ready held high, it completes in 3 cycles.
- R4: Push-multiple (extended opcode 26) stores register Rk at address P+1+k for k = 0..15, with R0 first. The pointer register ends at P+16. With ready held high, it completes in 33 cycles.
- R5: Pop-multiple (extended opcode 27) loads R15 from address P first and Rk from address P-15+k, with R0 last. The pointer register ends at P-16. With ready held high, it completes in 33 cycles.
- R6: When the pointer register lies inside R0..R15, its final value after either multiple form is the pointer after the sequence. During push-multiple, the word stored for it is its already-advanced value P+1+k.
- R7: Pointer arithmetic wraps modulo 2^32. A push from 0xFFFFFFFF uses address 0, and a pop from 0 leaves 0xFFFFFFFF.
- R8: `busy_o` is high from the cycle after an accepted start until the sequence ends. `done_o` is a single-cycle pulse and is never high together with `busy_o`.
- R9: While `mem_req_o` is high and `mem_ready_i` is low, the request, address and write enable hold. Results are the same when ready is withheld.
- R10: A start with any other extended opcode, or a start while busy, is ignored: no memory request and no register write follow from it.
- R11: A single push whose data register is the pointer register stores the incremented pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request for a transfer |
| xop_i | input | 12 | Decoded extended-opcode field |
| sp_sel_i | input | 5 | Number of the stack-pointer register |
| reg_sel_i | input | 5 | Data register for the single forms |
| busy_o | output | 1 | Transfer in progress; stalls the core |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rf_raddr_o | output | 5 | Register file read address |
| rf_rdata_i | input | 32 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 5 | Register file write address |
| rf_wdata_o | output | 32 | Register file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (high) or read (low) |
| mem_addr_o | output | 32 | Word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory accepts or completes the access |

## Verification
With ready held high, a single transfer raises `done_o` 3 cycles after the edge that samples start, and a multiple transfer raises it after 33 cycles. This follows from two cycles per word (one pointer write-back, one memory access) plus the registered done. The bench drives and samples on the falling edge and counts falling edges from the start edge until `done_o`, comparing that count where ready is not throttled. Register and memory contents are compared on the falling edge after `done_o`, when the last write has landed, and `busy_o`/`done_o` are checked on every one of those edges.

// File: rtl/stack_xfer_pkg.sv
package stack_xfer_pkg;
  localparam int unsigned XOP_W = 12;

  localparam logic [XOP_W-1:0] XOP_PUSH  = 12'd21;
  localparam logic [XOP_W-1:0] XOP_POP   = 12'd22;
  localparam logic [XOP_W-1:0] XOP_PUSHM = 12'd26;
  localparam logic [XOP_W-1:0] XOP_POPM  = 12'd27;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PTR  = 2'd1,
    ST_MEM  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic valid;
    logic push;
    logic multi;
  } xfer_kind_t;
endpackage

// File: rtl/stack_xfer_decode.sv
module stack_xfer_decode
  import stack_xfer_pkg::*;
(
  input  logic [XOP_W-1:0] xop_i,
  output xfer_kind_t       kind_o
);
  always_comb begin
    kind_o = '0;
    case (xop_i)
      XOP_PUSH:  kind_o = '{valid: 1'b1, push: 1'b1, multi: 1'b0};
      XOP_POP:   kind_o = '{valid: 1'b1, push: 1'b0, multi: 1'b0};
      XOP_PUSHM: kind_o = '{valid: 1'b1, push: 1'b1, multi: 1'b1};
      XOP_POPM:  kind_o = '{valid: 1'b1, push: 1'b0, multi: 1'b1};
      default:   kind_o = '0;
    endcase
  end
endmodule

// File: rtl/stack_xfer_ptr.sv
module stack_xfer_ptr #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              step_i,
  input  logic              up_i,
  output logic [DATA_W-1:0] ptr_o,
  output logic [DATA_W-1:0] ptr_next_o
);
  logic [DATA_W-1:0] ptr_q;

  // wraps modulo 2^DATA_W by width
  assign ptr_next_o = up_i ? ptr_q + DATA_W'(1) : ptr_q - DATA_W'(1);
  assign ptr_o      = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (load_i)  ptr_q <= load_val_i;
    else if (step_i)  ptr_q <= ptr_next_o;
  end
endmodule

// File: rtl/stack_xfer_ctrl.sv
module stack_xfer_ctrl
  import stack_xfer_pkg::*;
#(
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned WIN_REGS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  xfer_kind_t        kind_i,
  input  logic [REG_AW-1:0] sp_sel_i,
  input  logic [REG_AW-1:0] reg_sel_i,
  input  logic              mem_ready_i,
  output seq_state_e        state_o,
  output logic              push_o,
  output logic              accept_o,
  output logic              ptr_step_o,
  output logic              mem_fire_o,
  output logic [REG_AW-1:0] sp_idx_o,
  output logic [REG_AW-1:0] cur_idx_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = (WIN_REGS > 1) ? $clog2(WIN_REGS) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WIN_REGS - 1);

  seq_state_e        state_q;
  logic              push_q, multi_q, done_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [REG_AW-1:0] sp_idx_q, data_idx_q;
  logic              last, finish;

  assign last       = !multi_q || (push_q ? (cnt_q == CNT_TOP) : (cnt_q == '0));
  assign accept_o   = (state_q == ST_IDLE) && start_i && kind_i.valid;
  assign ptr_step_o = (state_q == ST_PTR);
  assign mem_fire_o = (state_q == ST_MEM) && mem_ready_i;
  assign finish     = (ptr_step_o && !push_q && last) || (mem_fire_o && push_q && last);
  assign cur_idx_o  = multi_q ? REG_AW'(cnt_q) : data_idx_q;
  assign state_o    = state_q;
  assign push_o     = push_q;
  assign sp_idx_o   = sp_idx_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      push_q     <= 1'b0;
      multi_q    <= 1'b0;
      cnt_q      <= '0;
      sp_idx_q   <= '0;
      data_idx_q <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= finish;
      case (state_q)
        ST_IDLE: if (accept_o) begin
          push_q     <= kind_i.push;
          multi_q    <= kind_i.multi;
          sp_idx_q   <= sp_sel_i;
          data_idx_q <= reg_sel_i;
          cnt_q      <= kind_i.push ? '0 : CNT_TOP;
          state_q    <= kind_i.push ? ST_PTR : ST_MEM;
        end
        ST_PTR: begin
          if (push_q) state_q <= ST_MEM;
          else if (last) state_q <= ST_IDLE;
          else begin
            cnt_q   <= cnt_q - CNT_W'(1);
            state_q <= ST_MEM;
          end
        end
        ST_MEM: if (mem_ready_i) begin
          if (!push_q) state_q <= ST_PTR;
          else if (last) state_q <= ST_IDLE;
          else begin
            cnt_q   <= cnt_q + CNT_W'(1);
            state_q <= ST_PTR;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_xfer_seq.sv
module stack_xfer_seq
  import stack_xfer_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned WIN_REGS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [XOP_W-1:0]  xop_i,
  input  logic [REG_AW-1:0] sp_sel_i,
  input  logic [REG_AW-1:0] reg_sel_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [REG_AW-1:0] rf_raddr_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  xfer_kind_t        kind;
  seq_state_e        state;
  logic              push, accept, ptr_step, mem_fire;
  logic [REG_AW-1:0] sp_idx, cur_idx;
  logic [DATA_W-1:0] ptr, ptr_next;

  stack_xfer_decode i_decode (
    .xop_i  (xop_i),
    .kind_o (kind)
  );

  stack_xfer_ctrl #(
    .REG_AW   (REG_AW),
    .WIN_REGS (WIN_REGS)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .kind_i      (kind),
    .sp_sel_i    (sp_sel_i),
    .reg_sel_i   (reg_sel_i),
    .mem_ready_i (mem_ready_i),
    .state_o     (state),
    .push_o      (push),
    .accept_o    (accept),
    .ptr_step_o  (ptr_step),
    .mem_fire_o  (mem_fire),
    .sp_idx_o    (sp_idx),
    .cur_idx_o   (cur_idx),
    .done_o      (done_o)
  );

  stack_xfer_ptr #(
    .DATA_W (DATA_W)
  ) i_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (rf_rdata_i),
    .step_i     (ptr_step),
    .up_i       (push),
    .ptr_o      (ptr),
    .ptr_next_o (ptr_next)
  );

  // idle: read pointer register; otherwise the current data register
  assign rf_raddr_o  = (state == ST_IDLE) ? sp_sel_i : cur_idx;
  assign busy_o      = (state != ST_IDLE);
  assign mem_req_o   = (state == ST_MEM);
  assign mem_we_o    = mem_req_o && push;
  assign mem_addr_o  = ptr;
  assign mem_wdata_o = rf_rdata_i;
  assign rf_we_o     = ptr_step || (mem_fire && !push);
  assign rf_waddr_o  = ptr_step ? sp_idx : cur_idx;
  assign rf_wdata_o  = ptr_step ? ptr_next : mem_rdata_i;
endmodule

// File: rtl/stack_xfer_chk.sv
module stack_xfer_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              rf_we_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [DATA_W-1:0] mem_addr_o,
  input logic              mem_ready_i
);
  assert_busy_done_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!mem_req_o && !rf_we_o));
endmodule

bind stack_xfer_seq stack_xfer_chk #(.DATA_W(DATA_W)) i_stack_xfer_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rf_we_o     (rf_we_o),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ready_i (mem_ready_i)
);

// File: tb/test_stack_xfer_seq.sv
`timescale 1ns/1ps
module test_stack_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] xop = '0;
  logic [4:0]  sp_sel = '0, reg_sel = '0;
  logic        busy, done, rf_we, mem_req, mem_we, mem_ready;
  logic [4:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata;
  logic        stall = 1'b0, tog = 1'b0;

  logic [31:0] rf [32];
  logic [31:0] mem [256];

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  always @(posedge clk) tog <= ~tog;
  assign mem_ready = stall ? tog : 1'b1;
  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
    if (mem_req && mem_ready && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  stack_xfer_seq i_stack_xfer_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .xop_i(xop),
    .sp_sel_i(sp_sel), .reg_sel_i(reg_sel), .busy_o(busy), .done_o(done),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // start at a falling edge; count falling edges until done; R8 checked throughout
  task automatic run_op(input logic [11:0] x, input logic [4:0] a, input logic [4:0] b,
                        input int exp_cyc, input string req);
    int cyc;
    logic bad;
    @(negedge clk);
    start = 1'b1; xop = x; sp_sel = a; reg_sel = b;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    bad = 1'b0;
    if (!busy) bad = 1'b1;
    while (!done && cyc < 500) begin
      @(negedge clk);
      cyc++;
      if (!done && !busy) bad = 1'b1;
      if (done && busy) bad = 1'b1;
    end
    chk("R8 busy spans transfer", 32'(bad), 32'd0);
    if (exp_cyc > 0) chk({req, " cycles to done"}, 32'(cyc), 32'(exp_cyc));
    @(negedge clk);
    chk("R8 done single pulse", {30'd0, done, busy}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 reset outputs", {28'd0, busy, done, mem_req, rf_we}, 32'd0);
  endtask

  task automatic t_push_single();
    rf[3] = 32'd10; rf[2] = 32'h0000_AAAA; mem[11] = '0;
    run_op(12'd21, 5'd3, 5'd2, 3, "R2");
    chk("R2 push stored word", mem[11], 32'h0000_AAAA);
    chk("R2 push pointer", rf[3], 32'd11);
  endtask

  task automatic t_pop_single();
    rf[7] = '0; mem[11] = 32'h1234_5678;
    run_op(12'd22, 5'd3, 5'd7, 3, "R3");
    chk("R3 pop loaded word", rf[7], 32'h1234_5678);
    chk("R3 pop pointer", rf[3], 32'd10);
  endtask

  task automatic t_multi(input int base, input logic [31:0] tag, input int exp_cyc, input string req);
    for (int i = 0; i < 16; i++) rf[i] = tag + 32'(i);
    rf[20] = 32'(base);
    run_op(12'd26, 5'd20, 5'd0, exp_cyc, req);
    chk({req, " R4 pushm pointer"}, rf[20], 32'(base + 16));
    for (int i = 0; i < 16; i++)
      chk({req, " R4 pushm word"}, mem[(base + 1 + i) & 255], tag + 32'(i));
    for (int i = 0; i < 16; i++) rf[i] = 32'hDEAD_0000;
    run_op(12'd27, 5'd20, 5'd0, exp_cyc, req);
    chk({req, " R5 popm pointer"}, rf[20], 32'(base));
    for (int i = 0; i < 16; i++)
      chk({req, " R5 popm register"}, rf[i], tag + 32'(i));
  endtask

  task automatic t_sp_in_window();
    for (int i = 0; i < 16; i++) rf[i] = 32'h300 + 32'(i);
    rf[5] = 32'h80;
    run_op(12'd26, 5'd5, 5'd0, 33, "R6");
    chk("R6 pushm pointer in window", rf[5], 32'h90);
    chk("R6 stored advanced pointer", mem[8'h86], 32'h86);
    chk("R6 neighbour stored", mem[8'h85], 32'h304);
    rf[4] = '0;
    run_op(12'd27, 5'd5, 5'd0, 33, "R6");
    chk("R6 popm pointer in window", rf[5], 32'h80);
    chk("R6 neighbour restored", rf[4], 32'h304);
  endtask

  task automatic t_wrap();
    rf[1] = 32'hFFFF_FFFF; rf[9] = 32'h0BAD_CAFE; mem[0] = '0;
    run_op(12'd21, 5'd1, 5'd9, 3, "R7");
    chk("R7 push wraps to 0", rf[1], 32'd0);
    chk("R7 word at address 0", mem[0], 32'h0BAD_CAFE);
    rf[9] = '0;
    run_op(12'd22, 5'd1, 5'd9, 3, "R7");
    chk("R7 pop wraps to all-ones", rf[1], 32'hFFFF_FFFF);
    chk("R7 pop data", rf[9], 32'h0BAD_CAFE);
  endtask

  task automatic t_stall();
    stall = 1'b1;
    t_multi(8'h10, 32'h200, 0, "R9");
    stall = 1'b0;
  endtask

  task automatic t_ignore();
    logic seen;
    rf[9] = 32'h77;
    @(negedge clk);
    start = 1'b1; xop = 12'd23; sp_sel = 5'd9; reg_sel = 5'd9;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (busy || mem_req || rf_we) seen = 1'b1;
      @(negedge clk);
    end
    chk("R10 unknown opcode ignored", 32'(seen), 32'd0);
    chk("R10 register untouched", rf[9], 32'h77);
    // start while busy
    rf[20] = 32'h40;
    @(negedge clk);
    start = 1'b1; xop = 12'd26; sp_sel = 5'd20;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; xop = 12'd22; sp_sel = 5'd9; reg_sel = 5'd9;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R10 start while busy ignored", rf[9], 32'h77);
    chk("R10 running transfer intact", rf[20], 32'h50);
  endtask

  task automatic t_self_push();
    rf[3] = 32'd20; mem[21] = '0;
    run_op(12'd21, 5'd3, 5'd3, 3, "R11");
    chk("R11 stores incremented pointer", mem[21], 32'd21);
    chk("R11 pointer", rf[3], 32'd21);
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_single();
    t_pop_single();
    t_multi(32'h40, 32'h100, 33, "R4/R5");
    t_sp_in_window();
    t_wrap();
    t_stall();
    t_ignore();
    t_self_push();
    summary();
    $finish;
  end
endmodule